// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers sixteen interrupt causes for an 8-bit processor core and offers it a single request at a time, together with the 16-bit address of the vector slot that belongs to the winning cause. The causes are of three kinds:

- eleven single-cycle pulses from on-chip peripherals;
- four pin-driven events: three edge-triggered pins, each with a selectable active edge, and one keypad wake-up formed from an 8-bit port;
- a software break request raised by the core itself.

Every cause has a pending latch and, except for the break, an enable bit. All of these bits, and the edge-select bits, are reachable through a small byte-wide register port. When the core acknowledges a request, the controller clears the latch of the winner it was showing in that same cycle. It also raises a one-cycle strobe that tells the core to set its interrupt-disable flag. Stacking the program counter and reading the vector out of memory stay with the core.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After synchronous reset, every pending latch, enable bit and edge-select bit reads 0, and `irq_pending_o` is 0.
- R2: A one-cycle pulse on `periph_evt_i[k]` sets pending bit S at the next clock edge. The mapping k to S is 0→0, 1→1, 2→2, 3→3, 4→5, 5→6, 6→7, 7→9, 8→10, 9→11, 10→14.
- R3: Pins `ext_pin_i[0]`, `[1]` and `[2]` set pending bits 4, 8 and 12 on their active edge, after a two-flop synchronizer. Edge-select bit p chooses the edge: 1 selects rising and 0 selects falling. The opposite edge has no effect.
- R4: Pending bit 13 is set on a falling edge of the AND of the synchronized `port_lvl_i` bits whose `port_out_i` bit is 0. Pins marked as outputs (`port_out_i` bit 1) do not take part.
- R5: A source 0..14 drives `irq_pending_o` only when its pending bit is 1, its enable bit is 1 and `cpu_iflag_i` is 0.
- R6: Pending bit 15 (break, set by a `brk_req_i` pulse) makes `irq_pending_o` 1 whatever the enable bits and `cpu_iflag_i` are.
- R7: Among eligible sources the lowest index wins. `vector_o` is 0xFFFA − 2·index, so index 0 gives 0xFFFA and index 15 gives 0xFFDC.
- R8: While `irq_pending_o` is 1, a cycle with `irq_ack_i` high does two things. It raises `iflag_set_o` in that same cycle, and it clears only the winner's pending bit at the clock edge. Every other pending bit stays set.
- R9: The register map is: address 0 holds pending[7:0], 1 holds pending[15:8], 2 holds enable[7:0], 3 holds enable[15:8], 4 holds the edge select in bits [2:0]. Writing 0 to a pending bit clears it, and writing 1 leaves it unchanged. Enables read back as written.
- R10: Changing an edge-select bit so that the polarity-adjusted pin level goes from 0 to 1 sets that pin's pending bit, exactly as a real edge would.
- R11: If a hardware event and a software clear hit the same pending bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_evt_i | input | 11 | Peripheral event pulses |
| brk_req_i | input | 1 | Software break pulse from the core |
| ext_pin_i | input | 3 | Asynchronous edge-triggered interrupt pins |
| port_lvl_i | input | 8 | Asynchronous levels of the wake-up port |
| port_out_i | input | 8 | Port direction, 1 = output (excluded from wake-up AND) |
| cpu_iflag_i | input | 1 | Core interrupt-disable flag |
| irq_ack_i | input | 1 | Core accepts the presented interrupt |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on address) |
| irq_pending_o | output | 1 | An eligible request exists |
| vector_o | output | 16 | Low-byte vector address of the winner |
| iflag_set_o | output | 1 | Strobe telling the core to set its disable flag |

## Verification
A pending latch that is wrongly set or stuck shows up in one of two places. It reads back wrong at register addresses 0 or 1, and, once enabled, it makes `irq_pending_o` and `vector_o` wrong within the same cycle. A broken edge detector or synchronizer shows up as a pending bit that is missing, or appears spuriously, about three clock edges after a pin moves. An acknowledge that clears the wrong latch makes the next vector wrong immediately after the acknowledge edge. The checks therefore focus on read-back after each stimulus and on the vector sequence across consecutive acknowledges.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int NSRC     = 16;
    localparam int NPERIPH  = 11;
    localparam int NPIN     = 3;
    localparam int NPORT    = 8;
    localparam int IDXW     = $clog2(NSRC);
    localparam int BRK_IDX  = NSRC - 1;
    localparam int KEY_IDX  = 13;
    localparam logic [15:0] VEC_TOP = 16'hFFFA;

    typedef enum logic [2:0] {
        RA_REQ_LO = 3'd0,
        RA_REQ_HI = 3'd1,
        RA_EN_LO  = 3'd2,
        RA_EN_HI  = 3'd3,
        RA_EDGE   = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic            valid;
        logic [IDXW-1:0] idx;
    } pick_t;

    typedef struct packed {
        logic      we;
        reg_addr_e addr;
        logic [7:0] wdata;
    } reg_wr_t;

    // vector slot address for a priority index
    function automatic logic [15:0] vec_of(input logic [IDXW-1:0] idx);
        return VEC_TOP - {{(15-IDXW){1'b0}}, idx, 1'b0};
    endfunction

    // position of peripheral event k in the priority order
    function automatic int periph_slot(input int k);
        case (k)
            0: return 0;
            1: return 1;
            2: return 2;
            3: return 3;
            4: return 5;
            5: return 6;
            6: return 7;
            7: return 9;
            8: return 10;
            9: return 11;
            default: return 14;
        endcase
    endfunction

    // position of edge pin p in the priority order
    function automatic int pin_slot(input int p);
        return 4 + 4 * p;
    endfunction
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge
    import irq_vec_pkg::*;
#(
    parameter int NP = NPIN,
    parameter int NW = NPORT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NP-1:0] pin_i,
    input  logic [NP-1:0] rise_sel_i,
    input  logic [NW-1:0] port_lvl_i,
    input  logic [NW-1:0] port_out_i,
    output logic [NP-1:0] pin_evt_o,
    output logic          key_evt_o
);
    for (genvar p = 0; p < NP; p++) begin : g_pin
        logic s1, s2, adj_prev;
        logic adj;
        // polarity-adjusted level: an active edge is always a 0->1 here
        assign adj = rise_sel_i[p] ? s2 : ~s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1       <= 1'b0;
                s2       <= 1'b0;
                adj_prev <= 1'b1;
            end else begin
                s1       <= pin_i[p];
                s2       <= s1;
                adj_prev <= adj;
            end
        end
        assign pin_evt_o[p] = adj & ~adj_prev;
    end

    logic [NW-1:0] port_s1, port_s2;
    logic          all_hi, all_hi_prev;

    assign all_hi = &(port_s2 | port_out_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            port_s1     <= '0;
            port_s2     <= '0;
            all_hi_prev <= 1'b0;
        end else begin
            port_s1     <= port_lvl_i;
            port_s2     <= port_s1;
            all_hi_prev <= all_hi;
        end
    end

    assign key_evt_o = all_hi_prev & ~all_hi;
endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank
    import irq_vec_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  reg_wr_t         wr,
    input  reg_addr_e       rd_addr,
    input  logic [NSRC-1:0] hw_set,
    input  logic [NSRC-1:0] ack_clr,
    output logic [NSRC-1:0] req_o,
    output logic [NSRC-1:0] en_o,
    output logic [NPIN-1:0] rise_sel_o,
    output logic [7:0]      rdata_o
);
    logic [NSRC-1:0] req_q, en_q, req_keep;
    logic [NPIN-1:0] sel_q;

    always_comb begin
        req_keep = '1;
        if (wr.we && wr.addr == RA_REQ_LO) req_keep[7:0]  = wr.wdata;
        if (wr.we && wr.addr == RA_REQ_HI) req_keep[15:8] = wr.wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            en_q  <= '0;
            sel_q <= '0;
        end else begin
            // software and acknowledge may only clear; hardware set wins
            req_q <= (req_q & req_keep & ~ack_clr) | hw_set;
            if (wr.we && wr.addr == RA_EN_LO) en_q[7:0]  <= wr.wdata;
            if (wr.we && wr.addr == RA_EN_HI) en_q[15:8] <= wr.wdata;
            if (wr.we && wr.addr == RA_EDGE)  sel_q      <= wr.wdata[NPIN-1:0];
        end
    end

    always_comb begin
        case (rd_addr)
            RA_REQ_LO: rdata_o = req_q[7:0];
            RA_REQ_HI: rdata_o = req_q[15:8];
            RA_EN_LO:  rdata_o = en_q[7:0];
            RA_EN_HI:  rdata_o = en_q[15:8];
            RA_EDGE:   rdata_o = {{(8-NPIN){1'b0}}, sel_q};
            default:   rdata_o = 8'h00;
        endcase
    end

    assign req_o      = req_q;
    assign en_o       = en_q;
    assign rise_sel_o = sel_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_vec_pkg::*;
(
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] en_i,
    input  logic            iflag_i,
    output pick_t           pick_o,
    output logic [15:0]     vector_o
);
    logic [NSRC-1:0] elig;

    always_comb begin
        elig          = req_i & en_i & {NSRC{~iflag_i}};
        elig[BRK_IDX] = req_i[BRK_IDX];
        pick_o        = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                pick_o.valid = 1'b1;
                pick_o.idx   = IDXW'(i);
            end
        end
    end

    assign vector_o = vec_of(pick_o.idx);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vec_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NPERIPH-1:0]  periph_evt_i,
    input  logic                brk_req_i,
    input  logic [NPIN-1:0]     ext_pin_i,
    input  logic [NPORT-1:0]    port_lvl_i,
    input  logic [NPORT-1:0]    port_out_i,
    input  logic                cpu_iflag_i,
    input  logic                irq_ack_i,
    input  logic                reg_we_i,
    input  logic [2:0]          reg_addr_i,
    input  logic [7:0]          reg_wdata_i,
    output logic [7:0]          reg_rdata_o,
    output logic                irq_pending_o,
    output logic [15:0]         vector_o,
    output logic                iflag_set_o
);
    logic [NSRC-1:0] hw_set, ack_clr, req_q, en_q;
    logic [NPIN-1:0] pin_evt, rise_sel;
    logic            key_evt, ack_taken;
    logic [IDXW-1:0] win_idx;
    logic [15:0]     vec_w;
    pick_t           pick;
    reg_wr_t         wr;

    assign wr.we    = reg_we_i;
    assign wr.addr  = reg_addr_e'(reg_addr_i);
    assign wr.wdata = reg_wdata_i;

    irq_pin_edge #(.NP(NPIN), .NW(NPORT)) u_edge (
        .clk        (clk),
        .rst        (rst),
        .pin_i      (ext_pin_i),
        .rise_sel_i (rise_sel),
        .port_lvl_i (port_lvl_i),
        .port_out_i (port_out_i),
        .pin_evt_o  (pin_evt),
        .key_evt_o  (key_evt)
    );

    for (genvar k = 0; k < NPERIPH; k++) begin : g_periph
        assign hw_set[periph_slot(k)] = periph_evt_i[k];
    end
    for (genvar p = 0; p < NPIN; p++) begin : g_pinmap
        assign hw_set[pin_slot(p)] = pin_evt[p];
    end
    assign hw_set[KEY_IDX] = key_evt;
    assign hw_set[BRK_IDX] = brk_req_i;

    irq_req_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr),
        .rd_addr    (reg_addr_e'(reg_addr_i)),
        .hw_set     (hw_set),
        .ack_clr    (ack_clr),
        .req_o      (req_q),
        .en_o       (en_q),
        .rise_sel_o (rise_sel),
        .rdata_o    (reg_rdata_o)
    );

    irq_prio_pick u_pick (
        .req_i    (req_q),
        .en_i     (en_q),
        .iflag_i  (cpu_iflag_i),
        .pick_o   (pick),
        .vector_o (vec_w)
    );

    assign win_idx       = pick.idx;
    assign ack_taken     = irq_ack_i & pick.valid;
    assign ack_clr       = ack_taken ? (NSRC'(1) << win_idx) : '0;
    assign irq_pending_o = pick.valid;
    assign vector_o      = vec_w;
    assign iflag_set_o   = ack_taken;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
    import irq_vec_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [NSRC-1:0] req_q,
    input logic [NSRC-1:0] hw_set,
    input logic [IDXW-1:0] win_idx,
    input logic            cpu_iflag_i,
    input logic            irq_ack_i,
    input logic            irq_pending_o,
    input logic [15:0]     vector_o
);
    p_mask_r5: assert property (@(posedge clk) disable iff (rst)
        (cpu_iflag_i && !req_q[BRK_IDX]) |-> !irq_pending_o);

    p_brk_r6: assert property (@(posedge clk) disable iff (rst)
        req_q[BRK_IDX] |-> irq_pending_o);

    p_vec_range_r7: assert property (@(posedge clk) disable iff (rst)
        irq_pending_o |-> (!vector_o[0] && vector_o >= 16'hFFDC && vector_o <= 16'hFFFA));

    p_ack_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_ack_i && irq_pending_o && !hw_set[win_idx]) |=> !req_q[$past(win_idx)]);

    p_no_sw_set_r9: assert property (@(posedge clk) disable iff (rst)
        (!rst) |=> ((req_q & ~$past(req_q) & ~$past(hw_set)) == '0));

    p_hw_wins_r11: assert property (@(posedge clk) disable iff (rst)
        (|hw_set) |=> ((req_q & $past(hw_set)) == $past(hw_set)));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_q         (req_q),
    .hw_set        (hw_set),
    .win_idx       (win_idx),
    .cpu_iflag_i   (cpu_iflag_i),
    .irq_ack_i     (irq_ack_i),
    .irq_pending_o (irq_pending_o),
    .vector_o      (vector_o)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] periph = '0;
    logic        brk = 1'b0;
    logic [2:0]  pins = '0;
    logic [7:0]  plvl = 8'hFF;
    logic [7:0]  pout = 8'h00;
    logic        iflag = 1'b0;
    logic        ack = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wd = '0;
    logic [7:0]  rdata;
    logic        pend, iset;
    logic [15:0] vec;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    irq_vector_ctrl dut (
        .clk(clk), .rst(rst), .periph_evt_i(periph), .brk_req_i(brk),
        .ext_pin_i(pins), .port_lvl_i(plvl), .port_out_i(pout),
        .cpu_iflag_i(iflag), .irq_ack_i(ack), .reg_we_i(we),
        .reg_addr_i(addr), .reg_wdata_i(wd), .reg_rdata_o(rdata),
        .irq_pending_o(pend), .vector_o(vec), .iflag_set_o(iset)
    );

    typedef struct { string tag; logic [15:0] val; } item_t;
    item_t sbq[$];

    task automatic push_exp(input string tag, input logic [15:0] v);
        item_t it;
        it.tag = tag;
        it.val = v;
        sbq.push_back(it);
    endtask

    task automatic observe(input logic [15:0] got);
        item_t it;
        it = sbq.pop_front();
        total++;
        if (got !== it.val) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", it.tag, got, it.val);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wd = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic chk_reg(input string tag, input logic [2:0] a, input logic [7:0] e);
        push_exp(tag, {8'h00, e});
        @(negedge clk);
        addr = a;
        #1 observe({8'h00, rdata});
    endtask

    // expected irq view: 0 when idle, else the vector
    task automatic chk_irq(input string tag, input logic p, input logic [15:0] v);
        push_exp(tag, p ? v : 16'h0000);
        @(negedge clk);
        #1 observe(pend ? vec : 16'h0000);
    endtask

    task automatic pulse_p(input int k);
        @(negedge clk);
        periph[k] = 1'b1;
        @(negedge clk);
        periph = '0;
    endtask

    task automatic do_ack(input string tag);
        @(negedge clk);
        ack = 1'b1;
        push_exp(tag, 16'h0001);
        #1 observe({15'h0, iset});
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic clr_all();
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        // R1 reset state
        chk_reg("R1 req lo", 3'd0, 8'h00);
        chk_reg("R1 req hi", 3'd1, 8'h00);
        chk_reg("R1 en lo", 3'd2, 8'h00);
        chk_reg("R1 en hi", 3'd3, 8'h00);
        chk_reg("R1 edge", 3'd4, 8'h00);
        chk_irq("R1 idle", 1'b0, 16'h0);
        cyc(4);

        // R2 peripheral pulses
        pulse_p(0);
        pulse_p(10);
        chk_reg("R2 slot0", 3'd0, 8'h01);
        chk_reg("R2 slot14", 3'd1, 8'h40);

        // R9 clear-only writes, enable read-back
        wr(3'd0, 8'hFE);
        chk_reg("R9 clear by 0", 3'd0, 8'h00);
        wr(3'd1, 8'hFF);
        chk_reg("R9 one keeps", 3'd1, 8'h40);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'hFF);
        chk_reg("R9 no sw set", 3'd0, 8'h00);
        wr(3'd2, 8'hA5);
        wr(3'd3, 8'h5A);
        chk_reg("R9 en lo rb", 3'd2, 8'hA5);
        chk_reg("R9 en hi rb", 3'd3, 8'h5A);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h00);

        // R5 masking
        pulse_p(4);
        chk_irq("R5 disabled", 1'b0, 16'h0);
        wr(3'd2, 8'h20);
        chk_irq("R5 enabled", 1'b1, 16'hFFF0);
        iflag = 1'b1;
        chk_irq("R5 iflag", 1'b0, 16'h0);

        // R6 break bypasses masks
        @(negedge clk); brk = 1'b1;
        @(negedge clk); brk = 1'b0;
        chk_irq("R6 break", 1'b1, 16'hFFDC);

        // R8 acknowledge
        do_ack("R8 iflag strobe");
        chk_reg("R8 brk cleared", 3'd1, 8'h00);
        chk_reg("R8 other kept", 3'd0, 8'h20);
        iflag = 1'b0;
        chk_irq("R8 next", 1'b1, 16'hFFF0);

        // R7 priority and vectors
        wr(3'd2, 8'h22);
        pulse_p(1);
        chk_irq("R7 slot1 wins", 1'b1, 16'hFFF8);
        do_ack("R8 ack1");
        chk_irq("R7 slot5 after", 1'b1, 16'hFFF0);
        do_ack("R8 ack2");
        chk_irq("R7 drained", 1'b0, 16'h0);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h40);
        pulse_p(10);
        chk_irq("R7 slot14", 1'b1, 16'hFFDE);
        wr(3'd3, 8'h00);
        clr_all();

        // R3 pin A falling by default
        @(negedge clk); pins[0] = 1'b1; cyc(4);
        chk_reg("R3 A rise ignored", 3'd0, 8'h00);
        @(negedge clk); pins[0] = 1'b0; cyc(4);
        chk_reg("R3 A fall", 3'd0, 8'h10);
        clr_all();
        wr(3'd4, 8'h01);
        cyc(2);
        chk_reg("R3 A sel no event", 3'd0, 8'h00);
        @(negedge clk); pins[0] = 1'b1; cyc(4);
        chk_reg("R3 A rise", 3'd0, 8'h10);
        clr_all();

        // R10 edge-select switch raises request
        wr(3'd4, 8'h00);
        cyc(2);
        chk_reg("R10 no raise", 3'd0, 8'h00);
        wr(3'd4, 8'h01);
        cyc(2);
        chk_reg("R10 raise", 3'd0, 8'h10);
        clr_all();

        // R3 pin B falling, pin C rising
        @(negedge clk); pins[1] = 1'b1; cyc(4);
        chk_reg("R3 B rise ignored", 3'd1, 8'h00);
        @(negedge clk); pins[1] = 1'b0; cyc(4);
        chk_reg("R3 B fall", 3'd1, 8'h01);
        clr_all();
        wr(3'd4, 8'h05);
        cyc(2);
        @(negedge clk); pins[2] = 1'b1; cyc(4);
        chk_reg("R3 C rise", 3'd1, 8'h10);
        clr_all();

        // R4 key wake-up
        @(negedge clk); pout = 8'h0F; cyc(4);
        @(negedge clk); plvl = 8'hFE; cyc(4);
        chk_reg("R4 output pin ignored", 3'd1, 8'h00);
        @(negedge clk); plvl = 8'h7E; cyc(4);
        chk_reg("R4 input fall", 3'd1, 8'h20);
        @(negedge clk); plvl = 8'hFF; cyc(4);
        clr_all();

        // R11 hardware set beats software clear
        @(negedge clk);
        periph[0] = 1'b1; we = 1'b1; addr = 3'd0; wd = 8'h00;
        @(negedge clk);
        periph = '0; we = 1'b0;
        chk_reg("R11 set wins", 3'd0, 8'h01);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule